// File: doc/BRIEF.md
# Timer Channel Clock Gate and Prescaler

This block produces the count-enable strobes that drive a bank of timer channels. There are up to eight general timer channels, an optional operating-system timer channel and a watchdog channel. Each channel picks one of three source enables with a one-hot field in its own control register, and divides that source by a power of four. A common stop register, changed through separate set and clear addresses, can freeze each channel. The three sources (peripheral, real-time and external) arrive as single-cycle enable pulses in the core clock domain. Each channel emits a one-cycle strobe on its own output bit.

Software reaches the block through a plain synchronous register port. Reads are combinational from the address. Writes take effect at the clock edge where the write strobe is high. Every channel output sits at the bit position of that channel's stop bit, so one index names a channel everywhere. Unless the block is built with a bus clock shared by all channels, a channel's control register accepts writes only while that channel runs.

Top module: `timer_clk_gate`

## Requirements
- R1: After reset every implemented stop bit is 1 and every prescale field is 0. The watchdog control register reads 0x02 (real-time source). All other implemented control registers read 0x04 (external source).
- R2: Control registers sit at address 0..7 for timers 0..7, 8 for the OS timer and 9 for the watchdog. Bit 0 selects the peripheral source, bit 1 the real-time source and bit 2 the external source. Bits 5:3 hold the prescale n. All higher bits read 0 and ignore writes.
- R3: A write to address 11 sets the stop bit of each channel whose data bit is 1. Data bits that are 0 leave their channels unchanged.
- R4: A write to address 12 clears the stop bit of each channel whose data bit is 1. Data bits that are 0 leave their channels unchanged.
- R5: Address 10 reads the stop status. Timers use bits 0..NUM_TMR-1, the OS timer uses bit 15 and the watchdog uses bit 16. A 1 means stopped. Bits of channels that are not implemented read 0 and cannot be set.
- R6: A running channel emits one strobe per 4^n pulses of its selected source. A prescale value above 5 divides by 1024.
- R7: A channel emits strobes only for the source its one-hot field selects. A field with no bit set, or with more than one bit set, produces no strobes, and the field still reads back as written.
- R8: A stopped channel emits no strobes and keeps its partial count. Counting resumes from that count when the channel is cleared.
- R9: With BUS_CLK_GLOBAL = 0, a write to the control register of a stopped channel is ignored.
- R10: An accepted control write restarts that channel's count from zero. A source pulse in the same cycle as the write is not counted.
- R11: The strobe appears on tick_o exactly one cycle after the source pulse that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 17 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 17 | Read data, combinational from bus_addr |
| src_pulse_i | input | 3 | Source enables: bit 0 peripheral, 1 real-time, 2 external |
| tick_o | output | 17 | Per-channel count strobes, indexed like the stop bits |

## Verification
A control write and the source pulse that would complete a channel's count can land in the same cycle. The bench provokes this on timer 0 with divide-by-4. It sends three peripheral pulses, then raises the fourth pulse together with a rewrite of the same control value. The collision is judged correct only if no strobe appears, and four more pulses then yield exactly one strobe, which shows that the write restarted the count and the colliding pulse was dropped. A second overlap is a stop-set write arriving while source pulses continue. That case is judged by the strobe count together with the partial count that survives.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int NSLOT   = 17;
  localparam int OST_BIT = 15;
  localparam int WDT_BIT = 16;
  localparam int SRCN    = 3;
  localparam int PSW     = 3;
  localparam int CTW     = SRCN + PSW;
  localparam int PS_MAX  = 5;
  localparam int CNTW    = 2 * PS_MAX;
  localparam int AW      = 4;
  localparam int DW      = NSLOT;

  localparam logic [AW-1:0] ADDR_STAT = 4'd10;
  localparam logic [AW-1:0] ADDR_SET  = 4'd11;
  localparam logic [AW-1:0] ADDR_CLR  = 4'd12;

  typedef struct packed {
    logic [PSW-1:0]  ps;
    logic [SRCN-1:0] src;
  } ctrl_t;

  localparam ctrl_t CTRL_RST_EXT = '{ps: '0, src: 3'b100};
  localparam ctrl_t CTRL_RST_RTC = '{ps: '0, src: 3'b010};

  function automatic logic [NSLOT-1:0] slot_mask(int ntmr, bit ost);
    logic [NSLOT-1:0] m;
    m = '0;
    for (int s = 0; s < NSLOT; s++)
      m[s] = (s < ntmr) || (s == OST_BIT && ost) || (s == WDT_BIT);
    return m;
  endfunction

  function automatic logic [AW-1:0] slot_addr(int s);
    if (s < 8)             return AW'(s);
    else if (s == OST_BIT) return 4'd8;
    else if (s == WDT_BIT) return 4'd9;
    else                   return 4'd15;
  endfunction
endpackage

// File: rtl/tcg_stop.sv
module tcg_stop
  import tcg_pkg::*;
#(
  parameter logic [NSLOT-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NSLOT-1:0] wdata,
  output logic [NSLOT-1:0] stop_q
);
  logic [NSLOT-1:0] hit;
  assign hit = wdata & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      stop_q <= MASK;
    else if (set_we) stop_q <= stop_q | hit;
    else if (clr_we) stop_q <= stop_q & ~hit;
  end
endmodule

// File: rtl/tcg_channel.sv
module tcg_channel
  import tcg_pkg::*;
#(
  parameter ctrl_t RST_CTRL = CTRL_RST_EXT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  ctrl_t           wr_ctrl,
  input  logic [SRCN-1:0] src_i,
  input  logic            run,
  output ctrl_t           ctrl_q,
  output logic            tick_o
);
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] last;
  logic [CNTW:0]   full;
  logic [PSW-1:0]  n_eff;
  logic            hit;

  always_comb begin
    n_eff = (ctrl_q.ps > PSW'(PS_MAX)) ? PSW'(PS_MAX) : ctrl_q.ps;
    full  = (CNTW+1)'(1) << {n_eff, 1'b0};
    last  = full[CNTW-1:0] - 1'b1;
    hit   = run && $onehot(ctrl_q.src) && |(src_i & ctrl_q.src);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= RST_CTRL;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (wr_en) begin
        ctrl_q <= wr_ctrl;
        cnt_q  <= '0;
      end else if (hit) begin
        if (cnt_q == last) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_clk_gate.sv
module timer_clk_gate
  import tcg_pkg::*;
#(
  parameter int NUM_TMR        = 8,
  parameter bit HAS_OST        = 1'b1,
  parameter bit BUS_CLK_GLOBAL = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [DW-1:0]   bus_rdata,
  input  logic [SRCN-1:0] src_pulse_i,
  output logic [NSLOT-1:0] tick_o
);
  localparam logic [NSLOT-1:0] MASK = slot_mask(NUM_TMR, HAS_OST);

  logic [NSLOT-1:0]        stop_q;
  ctrl_t [NSLOT-1:0]       ctrl_all;

  tcg_stop #(.MASK(MASK)) u_stop (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (bus_we && bus_addr == ADDR_SET),
    .clr_we (bus_we && bus_addr == ADDR_CLR),
    .wdata  (bus_wdata[NSLOT-1:0]),
    .stop_q (stop_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (MASK[s]) begin : g_on
      localparam ctrl_t RST_V = (s == WDT_BIT) ? CTRL_RST_RTC : CTRL_RST_EXT;
      logic accept;
      assign accept = bus_we && (bus_addr == slot_addr(s)) &&
                      (BUS_CLK_GLOBAL || !stop_q[s]);
      tcg_channel #(.RST_CTRL(RST_V)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_ctrl (ctrl_t'(bus_wdata[CTW-1:0])),
        .src_i   (src_pulse_i),
        .run     (!stop_q[s]),
        .ctrl_q  (ctrl_all[s]),
        .tick_o  (tick_o[s])
      );
    end else begin : g_off
      assign ctrl_all[s] = '0;
      assign tick_o[s]   = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STAT) bus_rdata = stop_q;
    for (int s = 0; s < NSLOT; s++)
      if (MASK[s] && bus_addr == slot_addr(s))
        bus_rdata[CTW-1:0] = ctrl_all[s];
  end
endmodule

// File: rtl/timer_clk_gate_chk.sv
module timer_clk_gate_chk
  import tcg_pkg::*;
#(
  parameter int NUM_TMR        = 8,
  parameter bit HAS_OST        = 1'b1,
  parameter bit BUS_CLK_GLOBAL = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic [DW-1:0]     bus_rdata,
  input logic [SRCN-1:0]   src_pulse_i,
  input logic [NSLOT-1:0]  tick_o,
  input logic [NSLOT-1:0]  stop_q,
  input ctrl_t [NSLOT-1:0] ctrl_all
);
  localparam logic [NSLOT-1:0] MASK = slot_mask(NUM_TMR, HAS_OST);

  p_quiet_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o & $past(stop_q)) == '0);

  p_tick_follows_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o != '0) |-> ($past(src_pulse_i) != '0));

  p_set_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_SET) |=>
      ((stop_q & $past(bus_wdata) & MASK) == ($past(bus_wdata) & MASK)));

  p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_CLR) |=> ((stop_q & $past(bus_wdata) & MASK) == '0));

  p_locked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!BUS_CLK_GLOBAL && bus_we && bus_addr == 4'd0 && stop_q[0]) |=> $stable(ctrl_all[0]));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr <= 4'd9) |-> (bus_rdata[DW-1:CTW] == '0));
endmodule

bind timer_clk_gate timer_clk_gate_chk #(
  .NUM_TMR(NUM_TMR), .HAS_OST(HAS_OST), .BUS_CLK_GLOBAL(BUS_CLK_GLOBAL)
) u_chk (.*);

// File: tb/timer_clk_gate_test.sv
module timer_clk_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [16:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [16:0] bus_rdata;
  logic [2:0]  src_pulse_i = '0;
  logic [16:0] tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tcnt [17];

  timer_clk_gate #(.NUM_TMR(2), .HAS_OST(1'b1), .BUS_CLK_GLOBAL(1'b0)) uut (.*);

  always #5 clk = ~clk;

  always @(negedge clk)
    for (int i = 0; i < 17; i++) if (tick_o[i]) tcnt[i]++;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [16:0] d);
    @(posedge clk); #1 bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    bus_addr = a;
    @(negedge clk); v = int'(bus_rdata);
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 17; i++) tcnt[i] = 0;
  endtask

  task automatic pulse(logic [2:0] pat, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 src_pulse_i = pat;
    end
    @(posedge clk); #1 src_pulse_i = '0;
    @(negedge clk); @(negedge clk);
  endtask

  int v;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R5 reset state
    rd(4'd10, v); chk("R1 R5 reset status", v, 'h18003);
    rd(4'd0, v);  chk("R1 timer0 reset ctrl", v, 'h04);
    rd(4'd8, v);  chk("R1 ost reset ctrl", v, 'h04);
    rd(4'd9, v);  chk("R1 wdt reset ctrl", v, 'h02);
    rd(4'd2, v);  chk("R5 unimplemented timer2 reads 0", v, 0);

    // R9 write while stopped ignored
    wr(4'd0, 'h09); rd(4'd0, v); chk("R9 stopped write ignored", v, 'h04);

    // R5 unimplemented bit, R3 zero bits, R4 clear
    wr(4'd11, 'h20); rd(4'd10, v); chk("R5 unimplemented stop bit", v, 'h18003);
    wr(4'd12, 'h0);  rd(4'd10, v); chk("R4 zero clear unchanged", v, 'h18003);
    wr(4'd12, 'h1);  rd(4'd10, v); chk("R4 clear timer0", v, 'h18002);

    // R2 reserved bits
    wr(4'd0, 17'h1FF01); rd(4'd0, v); chk("R2 reserved bits read 0", v, 'h01);

    // R11 latency
    clr_cnt();
    @(posedge clk); #1 src_pulse_i = 3'b001;
    @(negedge clk); chk("R11 no tick same cycle", int'(tick_o[0]), 0);
    @(posedge clk); #1 src_pulse_i = '0;
    @(negedge clk); chk("R11 tick one cycle later", int'(tick_o[0]), 1);
    @(negedge clk); chk("R11 tick single cycle", int'(tick_o[0]), 0);

    // R6 / R7 / R8 sweep of source and prescale on timer0
    for (int n = 0; n < 8; n++) begin
      for (int s = 0; s < 3; s++) begin
        int ne, div, w, np;
        ne = (n > 5) ? 5 : n;
        div = 1 << (2 * ne);
        w = 6 * div + 3;
        np = 0;
        wr(4'd0, 17'((n << 3) | (1 << s)));
        clr_cnt();
        for (int i = 0; i < w; i++) begin
          logic [2:0] p;
          p = {(i % 3) == 0, (i % 2) == 0, 1'b1};
          if (p[s]) np++;
          @(posedge clk); #1 src_pulse_i = p;
        end
        @(posedge clk); #1 src_pulse_i = '0;
        @(negedge clk); @(negedge clk);
        chk($sformatf("R6 R7 timer0 n=%0d src=%0d", n, s), tcnt[0], np / div);
        chk("R8 stopped timer1 silent", tcnt[1], 0);
        chk("R8 stopped ost/wdt silent", tcnt[15] + tcnt[16], 0);
      end
    end

    // R7 invalid source fields
    wr(4'd0, 'h00); clr_cnt(); pulse(3'b111, 40);
    chk("R7 empty source no ticks", tcnt[0], 0);
    wr(4'd0, 'h07); clr_cnt(); pulse(3'b111, 40);
    chk("R7 multi source no ticks", tcnt[0], 0);
    rd(4'd0, v); chk("R7 invalid field reads back", v, 'h07);

    // R10 write collides with completing pulse
    wr(4'd0, 'h09); clr_cnt();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 src_pulse_i = 3'b001;
    end
    @(posedge clk); #1 bus_addr = 4'd0; bus_wdata = 'h09; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0; src_pulse_i = '0;
    @(negedge clk); @(negedge clk);
    chk("R10 colliding pulse dropped", tcnt[0], 0);
    pulse(3'b001, 4);
    chk("R10 count restarted", tcnt[0], 1);

    // R8 / R3 / R4 hold count through stop on watchdog
    wr(4'd12, 17'h10000); rd(4'd10, v); chk("R4 clear wdt", v, 'h08002);
    wr(4'd9, 'h0A); rd(4'd9, v); chk("R2 wdt ctrl write", v, 'h0A);
    clr_cnt(); pulse(3'b010, 3);
    chk("R6 wdt partial count", tcnt[16], 0);
    wr(4'd11, 17'h10000); rd(4'd10, v); chk("R3 set wdt stop", v, 'h18002);
    pulse(3'b010, 5);
    chk("R8 stopped wdt silent", tcnt[16], 0);
    wr(4'd12, 17'h10000);
    pulse(3'b010, 1);
    chk("R8 count held through stop", tcnt[16], 1);

    summary();
  end
endmodule